// File: doc/BRIEF.md
# Register File with Bus Selects

This block holds the working registers of a small 8-bit processor datapath. It has two general-purpose bytes, a 16-bit index register, a 16-bit stack pointer, a 16-bit program counter, a 16-bit memory address register, an 8-bit status register and an 8-bit scratch register. Every one of them is written from one shared result bus. A 4-bit load code picks which register captures the result on the rising clock edge. The two bytes of the memory address register have their own write enables, which work apart from that code. This lets a sequencer write a stack pointer byte and the matching address byte with a single result in one cycle.

The block reads out through three source selects, one for each output bus. The left select can choose any byte of any visible register, or the external data byte. The right select chooses the scratch register or the external data byte. The address select chooses the program counter or the memory address register as a 16-bit address. Each select has a code that drives nothing, and that code, like every reserved code, gives zero. The program counter steps by one on a fetch-done strobe. Four status bits can each be set from ALU flag inputs under their own enables. All eight status bits leave the block on a dedicated output, where the sequencer can test them.

Top module: `rfb_core`

## Requirements
- R1: A synchronous active-high reset sets every register to zero, so after reset every bus reads 0 for every select and the status output is 0.
- R2: On a rising edge only the register named by the load code captures the result bus. The load codes are 1 gp0, 2 gp1, 3 index low, 4 index high, 5 PC low, 6 PC high, 7 stack low, 8 stack high, 9 status and 10 scratch. Codes 0 and 11 to 15 load nothing.
- R3: The address-register low and high write enables capture the result bus whatever the load code is. A stack byte and an address byte can therefore take the same result in the same cycle.
- R4: The left select codes are 1 gp0, 2 gp1, 3 index low, 4 index high, 5 PC low, 6 PC high, 7 stack low, 8 stack high, 9 status and 10 external data.
- R5: The right select codes are 1 scratch and 2 external data.
- R6: The address select codes are 1 program counter ({high,low}) and 2 address register ({high,low}).
- R7: Select code 0 and every reserved select code (left 11 to 15, right 3, address 3 to 7) give an output of 0.
- R8: A fetch-done strobe adds one to the 16-bit program counter, with the carry going into the high byte. If a PC byte is loaded in the same cycle, the load wins and no step happens.
- R9: Status bit 0 is carry, bit 1 is zero, bit 2 is overflow and bit 3 is negative. Each of these bits takes its flag input when its own enable is high. Bits whose enable is low keep their value.
- R10: A status load through the load code (code 9) writes all 8 bits and takes priority over the flag enables. Bits 4 to 7 change only this way.
- R11: The status output always shows the 8 status bits.
- R12: The PC byte read on the left bus always equals the matching byte of the PC value on the address bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| res_bus | input | 8 | Result bus from the ALU |
| ld_sel | input | 4 | Load code |
| mar_lo_we | input | 1 | Address register low-byte write enable |
| mar_hi_we | input | 1 | Address register high-byte write enable |
| pc_inc | input | 1 | Fetch-done strobe, steps the PC |
| flag_we | input | 4 | Per-flag update enables (carry, zero, overflow, negative) |
| flag_in | input | 4 | Flag values from the ALU, same bit order |
| data_in | input | 8 | External data byte |
| lsel | input | 4 | Left bus source select |
| rsel | input | 2 | Right bus source select |
| asel | input | 3 | Address bus source select |
| lbus | output | 8 | Left bus |
| rbus | output | 8 | Right bus |
| abus | output | 16 | Address bus |
| status_out | output | 8 | Status bits to the sequencer |

## Verification
The assertions assume that every control input holds a known 0 or 1 at each rising edge once reset is released. They also assume that reset is high at the first clock edge, because the hold and step properties compare against the previous cycle. The stimulus drives all inputs on the falling edge from fixed or pseudo-random values, so no X reaches a select or enable. It holds reset through the first edges and again for one edge in the middle of the run. The random part draws over the full range of every code, reserved values included. It also lets PC loads collide with the step strobe, and status loads collide with flag enables.

// File: rtl/rfb_pkg.sv
`timescale 1ns/1ps
package rfb_pkg;

    localparam int DW    = 8;
    localparam int AW    = 2 * DW;
    localparam int NFLAG = 4;

    // flag bit positions inside the status byte
    localparam int FLG_C = 0;
    localparam int FLG_Z = 1;
    localparam int FLG_V = 2;
    localparam int FLG_N = 3;

    typedef enum logic [3:0] {
        LD_NONE = 4'd0,
        LD_GP0  = 4'd1,
        LD_GP1  = 4'd2,
        LD_IXL  = 4'd3,
        LD_IXH  = 4'd4,
        LD_PCL  = 4'd5,
        LD_PCH  = 4'd6,
        LD_SPL  = 4'd7,
        LD_SPH  = 4'd8,
        LD_STAT = 4'd9,
        LD_TMP  = 4'd10
    } ld_code_e;

    typedef enum logic [3:0] {
        LS_NONE = 4'd0,
        LS_GP0  = 4'd1,
        LS_GP1  = 4'd2,
        LS_IXL  = 4'd3,
        LS_IXH  = 4'd4,
        LS_PCL  = 4'd5,
        LS_PCH  = 4'd6,
        LS_SPL  = 4'd7,
        LS_SPH  = 4'd8,
        LS_STAT = 4'd9,
        LS_DIN  = 4'd10
    } lsrc_e;

    typedef enum logic [1:0] {
        RS_NONE = 2'd0,
        RS_TMP  = 2'd1,
        RS_DIN  = 2'd2
    } rsrc_e;

    typedef enum logic [2:0] {
        AS_NONE = 3'd0,
        AS_PC   = 3'd1,
        AS_MAR  = 3'd2
    } asrc_e;

    typedef struct packed {
        logic [DW-1:0] gp0;
        logic [DW-1:0] gp1;
        logic [DW-1:0] ixl;
        logic [DW-1:0] ixh;
        logic [DW-1:0] pcl;
        logic [DW-1:0] pch;
        logic [DW-1:0] spl;
        logic [DW-1:0] sph;
        logic [DW-1:0] tmp;
        logic [DW-1:0] marl;
        logic [DW-1:0] marh;
    } regs_t;

    function automatic logic is_pc_load(input logic [3:0] code);
        return (code == LD_PCL) || (code == LD_PCH);
    endfunction

endpackage

// File: rtl/rfb_store.sv
`timescale 1ns/1ps
module rfb_store
    import rfb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] res,
    input  logic [3:0]    ld_sel,
    input  logic          mar_lo_we,
    input  logic          mar_hi_we,
    input  logic          pc_inc,
    output regs_t         q
);

    logic [AW-1:0] pc_cur;
    logic [AW-1:0] pc_next;

    assign pc_cur  = {q.pch, q.pcl};
    assign pc_next = pc_cur + AW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            case (ld_sel)
                LD_GP0: q.gp0 <= res;
                LD_GP1: q.gp1 <= res;
                LD_IXL: q.ixl <= res;
                LD_IXH: q.ixh <= res;
                LD_PCL: q.pcl <= res;
                LD_PCH: q.pch <= res;
                LD_SPL: q.spl <= res;
                LD_SPH: q.sph <= res;
                LD_TMP: q.tmp <= res;
                default: ;
            endcase
            if (mar_lo_we) q.marl <= res;
            if (mar_hi_we) q.marh <= res;
            if (pc_inc && !is_pc_load(ld_sel)) begin
                q.pch <= pc_next[AW-1:DW];
                q.pcl <= pc_next[DW-1:0];
            end
        end
    end

    // R2: a register not addressed by the load code keeps its value
    a_r2_gp0_holds: assert property (@(posedge clk) disable iff (rst)
        (ld_sel != LD_GP0) |=> $stable(q.gp0));

    // R3: address register bytes follow their own enables
    a_r3_marl_load: assert property (@(posedge clk) disable iff (rst)
        mar_lo_we |=> (q.marl == $past(res)));
    a_r3_marh_load: assert property (@(posedge clk) disable iff (rst)
        mar_hi_we |=> (q.marh == $past(res)));

    // R8: strobe without a PC load steps the 16-bit counter
    a_r8_pc_step: assert property (@(posedge clk) disable iff (rst)
        (pc_inc && ld_sel != LD_PCL && ld_sel != LD_PCH)
        |=> ({q.pch, q.pcl} == $past({q.pch, q.pcl}) + AW'(1)));

endmodule

// File: rtl/rfb_status.sv
`timescale 1ns/1ps
module rfb_status
    import rfb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DW-1:0]    res,
    input  logic             ld_stat,
    input  logic [NFLAG-1:0] flag_we,
    input  logic [NFLAG-1:0] flag_in,
    output logic [DW-1:0]    stat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
        end else if (ld_stat) begin
            stat <= res;
        end else begin
            for (int i = 0; i < NFLAG; i++) begin
                if (flag_we[i]) stat[i] <= flag_in[i];
            end
        end
    end

    // R10: a full-byte load overrides any flag enables
    a_r10_bus_wins: assert property (@(posedge clk) disable iff (rst)
        ld_stat |=> (stat == $past(res)));

    for (genvar i = 0; i < DW; i++) begin : g_bit
        if (i < NFLAG) begin : g_flag
            // R9: a flag with its enable low and no byte load keeps its value
            a_r9_flag_hold: assert property (@(posedge clk) disable iff (rst)
                (!ld_stat && !flag_we[i]) |=> (stat[i] == $past(stat[i])));
        end else begin : g_upper
            // R10: upper bits only move through a byte load
            a_r10_upper_hold: assert property (@(posedge clk) disable iff (rst)
                !ld_stat |=> (stat[i] == $past(stat[i])));
        end
    end

endmodule

// File: rtl/rfb_bus_mux.sv
`timescale 1ns/1ps
module rfb_bus_mux
    import rfb_pkg::*;
(
    input  regs_t         q,
    input  logic [DW-1:0] stat,
    input  logic [DW-1:0] din,
    input  logic [3:0]    lsel,
    input  logic [1:0]    rsel,
    input  logic [2:0]    asel,
    output logic [DW-1:0] lbus,
    output logic [DW-1:0] rbus,
    output logic [AW-1:0] abus
);

    always_comb begin
        case (lsel)
            LS_GP0:  lbus = q.gp0;
            LS_GP1:  lbus = q.gp1;
            LS_IXL:  lbus = q.ixl;
            LS_IXH:  lbus = q.ixh;
            LS_PCL:  lbus = q.pcl;
            LS_PCH:  lbus = q.pch;
            LS_SPL:  lbus = q.spl;
            LS_SPH:  lbus = q.sph;
            LS_STAT: lbus = stat;
            LS_DIN:  lbus = din;
            default: lbus = '0;
        endcase
    end

    always_comb begin
        case (rsel)
            RS_TMP:  rbus = q.tmp;
            RS_DIN:  rbus = din;
            default: rbus = '0;
        endcase
    end

    always_comb begin
        case (asel)
            AS_PC:   abus = {q.pch, q.pcl};
            AS_MAR:  abus = {q.marh, q.marl};
            default: abus = '0;
        endcase
    end

endmodule

// File: rtl/rfb_core.sv
`timescale 1ns/1ps
module rfb_core
    import rfb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  res_bus,
    input  logic [3:0]  ld_sel,
    input  logic        mar_lo_we,
    input  logic        mar_hi_we,
    input  logic        pc_inc,
    input  logic [3:0]  flag_we,
    input  logic [3:0]  flag_in,
    input  logic [7:0]  data_in,
    input  logic [3:0]  lsel,
    input  logic [1:0]  rsel,
    input  logic [2:0]  asel,
    output logic [7:0]  lbus,
    output logic [7:0]  rbus,
    output logic [15:0] abus,
    output logic [7:0]  status_out
);

    regs_t         regs_q;
    logic [DW-1:0] stat_q;

    rfb_store u_store (
        .clk       (clk),
        .rst       (rst),
        .res       (res_bus),
        .ld_sel    (ld_sel),
        .mar_lo_we (mar_lo_we),
        .mar_hi_we (mar_hi_we),
        .pc_inc    (pc_inc),
        .q         (regs_q)
    );

    rfb_status u_status (
        .clk     (clk),
        .rst     (rst),
        .res     (res_bus),
        .ld_stat (ld_sel == LD_STAT),
        .flag_we (flag_we),
        .flag_in (flag_in),
        .stat    (stat_q)
    );

    rfb_bus_mux u_mux (
        .q    (regs_q),
        .stat (stat_q),
        .din  (data_in),
        .lsel (lsel),
        .rsel (rsel),
        .asel (asel),
        .lbus (lbus),
        .rbus (rbus),
        .abus (abus)
    );

    assign status_out = stat_q;

    // R1: the cycle after reset the status output is clear
    a_r1_cleared: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (status_out == '0));

    // R5: external data seen identically on both operand buses
    a_r5_din_both: assert property (@(posedge clk) disable iff (rst)
        (lsel == LS_DIN && rsel == RS_DIN) |-> (lbus == rbus));

    // R12: left-bus PC byte matches the address-bus PC value
    a_r12_pc_copy: assert property (@(posedge clk) disable iff (rst)
        (lsel == LS_PCL && asel == AS_PC) |-> (lbus == abus[7:0]));

endmodule

// File: tb/sim_rfb_core.sv
`timescale 1ns/1ps
module sim_rfb_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  res_bus = '0;
    logic [3:0]  ld_sel = '0;
    logic        mar_lo_we = 1'b0;
    logic        mar_hi_we = 1'b0;
    logic        pc_inc = 1'b0;
    logic [3:0]  flag_we = '0;
    logic [3:0]  flag_in = '0;
    logic [7:0]  data_in = '0;
    logic [3:0]  lsel = '0;
    logic [1:0]  rsel = '0;
    logic [2:0]  asel = '0;
    logic [7:0]  lbus;
    logic [7:0]  rbus;
    logic [15:0] abus;
    logic [7:0]  status_out;

    int nchk = 0;
    int nfail = 0;

    // reference state, indexed by load code (9 = status)
    logic [7:0] mr [0:15];
    logic [7:0] mmarl;
    logic [7:0] mmarh;

    always #10 clk = ~clk;

    rfb_core u0 (
        .clk(clk), .rst(rst), .res_bus(res_bus), .ld_sel(ld_sel),
        .mar_lo_we(mar_lo_we), .mar_hi_we(mar_hi_we), .pc_inc(pc_inc),
        .flag_we(flag_we), .flag_in(flag_in), .data_in(data_in),
        .lsel(lsel), .rsel(rsel), .asel(asel),
        .lbus(lbus), .rbus(rbus), .abus(abus), .status_out(status_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_left(input logic [3:0] s, input logic [7:0] d);
        if (s >= 4'd1 && s <= 4'd9) return mr[s];
        if (s == 4'd10) return d;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_right(input logic [1:0] s, input logic [7:0] d);
        if (s == 2'd1) return mr[10];
        if (s == 2'd2) return d;
        return 8'h00;
    endfunction

    function automatic logic [15:0] exp_addr(input logic [2:0] s);
        if (s == 3'd1) return {mr[6], mr[5]};
        if (s == 3'd2) return {mmarh, mmarl};
        return 16'h0000;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < 16; i++) mr[i] = 8'h00;
        mmarl = 8'h00;
        mmarh = 8'h00;
    endtask

    // apply inputs just after the falling edge and compare all outputs
    task automatic drive(input logic [7:0] r, input logic [3:0] ld, input logic mlo,
                         input logic mhi, input logic inc, input logic [3:0] fwe,
                         input logic [3:0] fin, input logic [7:0] d,
                         input logic [3:0] ls, input logic [1:0] rs, input logic [2:0] as);
        res_bus = r; ld_sel = ld; mar_lo_we = mlo; mar_hi_we = mhi; pc_inc = inc;
        flag_we = fwe; flag_in = fin; data_in = d; lsel = ls; rsel = rs; asel = as;
        #2;
        chk((ls == 0 || ls > 10) ? "R7 left" : "R4 left", {8'h00, lbus}, {8'h00, exp_left(ls, d)});
        chk((rs == 0 || rs == 3) ? "R7 right" : "R5 right", {8'h00, rbus}, {8'h00, exp_right(rs, d)});
        chk((as == 0 || as > 2) ? "R7 addr" : "R6 addr", abus, exp_addr(as));
        chk("R11 status", {8'h00, status_out}, {8'h00, mr[9]});
    endtask

    task automatic sel(input logic [3:0] ls, input logic [1:0] rs, input logic [2:0] as);
        drive(8'h00, 4'd0, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 8'h00, ls, rs, as);
    endtask

    // clock edge, then reference update from the applied inputs
    task automatic tick();
        logic [15:0] pc_old;
        @(posedge clk);
        #1;
        if (rst) begin
            model_clear();
        end else begin
            pc_old = {mr[6], mr[5]};
            if (ld_sel >= 4'd1 && ld_sel <= 4'd10) mr[ld_sel] = res_bus;
            if (mar_lo_we) mmarl = res_bus;
            if (mar_hi_we) mmarh = res_bus;
            if (pc_inc && ld_sel != 4'd5 && ld_sel != 4'd6) {mr[6], mr[5]} = pc_old + 16'd1;
            if (ld_sel != 4'd9)
                for (int i = 0; i < 4; i++) if (flag_we[i]) mr[9][i] = flag_in[i];
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        model_clear();
        rst = 1'b1;
        @(negedge clk);
        tick();
        tick();
        rst = 1'b0;

        // R1: every source reads zero after reset
        for (int l = 1; l <= 9; l++) begin
            sel(4'(l), 2'd1, 3'd1);
            chk("R1 left after reset", {8'h00, lbus}, 16'h0000);
            tick();
        end
        sel(4'd0, 2'd1, 3'd2);
        chk("R1 mar after reset", abus, 16'h0000);
        chk("R1 tmp after reset", {8'h00, rbus}, 16'h0000);
        tick();

        // R2: load gp0 only
        drive(8'h5A, 4'd1, 0, 0, 0, 4'h0, 4'h0, 8'h00, 4'd0, 2'd0, 3'd0);
        tick();
        sel(4'd1, 2'd0, 3'd0);
        chk("R2 gp0 loaded", {8'h00, lbus}, 16'h005A);
        tick();
        sel(4'd2, 2'd0, 3'd0);
        chk("R2 gp1 untouched", {8'h00, lbus}, 16'h0000);
        tick();
        // reserved load code writes nothing
        drive(8'hFF, 4'd13, 0, 0, 0, 4'h0, 4'h0, 8'h00, 4'd0, 2'd0, 3'd0);
        tick();
        sel(4'd1, 2'd1, 3'd0);
        chk("R2 reserved load gp0", {8'h00, lbus}, 16'h005A);
        chk("R2 reserved load tmp", {8'h00, rbus}, 16'h0000);
        tick();

        // R3: stack byte and address byte from one result
        drive(8'h34, 4'd7, 1, 0, 0, 4'h0, 4'h0, 8'h00, 4'd0, 2'd0, 3'd0);
        tick();
        drive(8'h12, 4'd8, 0, 1, 0, 4'h0, 4'h0, 8'h00, 4'd0, 2'd0, 3'd0);
        tick();
        sel(4'd7, 2'd0, 3'd2);
        chk("R3 mar pair", abus, 16'h1234);
        chk("R3 stack low", {8'h00, lbus}, 16'h0034);
        tick();

        // R8: carry into high byte, and load beats step
        drive(8'hFF, 4'd5, 0, 0, 0, 4'h0, 4'h0, 8'h00, 4'd0, 2'd0, 3'd0);
        tick();
        drive(8'h00, 4'd0, 0, 0, 1, 4'h0, 4'h0, 8'h00, 4'd0, 2'd0, 3'd0);
        tick();
        sel(4'd6, 2'd0, 3'd1);
        chk("R8 pc carry", abus, 16'h0100);
        chk("R12 pc high copy", {8'h00, lbus}, {8'h00, abus[15:8]});
        tick();
        drive(8'h77, 4'd5, 0, 0, 1, 4'h0, 4'h0, 8'h00, 4'd0, 2'd0, 3'd0);
        tick();
        sel(4'd5, 2'd0, 3'd1);
        chk("R8 load wins", abus, 16'h0177);
        chk("R12 pc low copy", {8'h00, lbus}, {8'h00, abus[7:0]});
        tick();

        // R9: only zero flag (bit 1) enabled
        drive(8'h00, 4'd0, 0, 0, 0, 4'b0010, 4'b1111, 8'h00, 4'd0, 2'd0, 3'd0);
        tick();
        sel(4'd9, 2'd0, 3'd0);
        chk("R9 zero only", {8'h00, status_out}, 16'h0002);
        tick();
        // R10: byte load beats flag enables
        drive(8'hA5, 4'd9, 0, 0, 0, 4'b1111, 4'b0000, 8'h00, 4'd0, 2'd0, 3'd0);
        tick();
        sel(4'd9, 2'd0, 3'd0);
        chk("R10 byte load", {8'h00, status_out}, 16'h00A5);
        chk("R10 left status", {8'h00, lbus}, 16'h00A5);
        tick();
        // R9: clear negative (bit 3) and set carry (bit 0)
        drive(8'h00, 4'd0, 0, 0, 0, 4'b1001, 4'b0001, 8'h00, 4'd0, 2'd0, 3'd0);
        tick();
        sel(4'd0, 2'd0, 3'd0);
        chk("R9 neg and carry", {8'h00, status_out}, 16'h00A5);
        tick();
        drive(8'h00, 4'd0, 0, 0, 0, 4'b1000, 4'b0000, 8'h00, 4'd0, 2'd0, 3'd0);
        tick();
        sel(4'd0, 2'd0, 3'd0);
        chk("R9 neg cleared", {8'h00, status_out}, 16'h00A5 & 16'h00F7);
        tick();

        // R5 and R7: right bus sources and reserved codes
        drive(8'h3C, 4'd10, 0, 0, 0, 4'h0, 4'h0, 8'hC3, 4'd10, 2'd2, 3'd0);
        chk("R5 din right", {8'h00, rbus}, 16'h00C3);
        tick();
        sel(4'd12, 2'd1, 3'd5);
        chk("R5 tmp right", {8'h00, rbus}, 16'h003C);
        chk("R7 left reserved", {8'h00, lbus}, 16'h0000);
        chk("R7 addr reserved", abus, 16'h0000);
        tick();
        sel(4'd0, 2'd3, 3'd0);
        chk("R7 right reserved", {8'h00, rbus}, 16'h0000);
        tick();

        // random traffic against the reference
        for (int n = 0; n < 600; n++) begin
            drive(8'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 4'($urandom), 4'($urandom), 8'($urandom),
                  4'($urandom), 2'($urandom), 3'($urandom));
            tick();
        end

        // R1: reset in mid run
        rst = 1'b1;
        tick();
        rst = 1'b0;
        for (int l = 0; l < 11; l++) begin
            sel(4'(l), 2'(l), 3'(l));
            chk("R1 mid-run reset", {8'h00, lbus}, 16'h0000);
            tick();
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule